// File: doc/BRIEF.md
# Flash Byte Programming Sequencer

This block is a host-side bus master that writes a run of bytes into a byte-wide electrically erasable flash using the pulse-and-verify method. After a start pulse it waits out the ramp of the high programming supply. It then works through the target addresses from zero upward. For each byte it sends the program set-up command, writes the wanted byte to the target address, waits for the program pulse to finish and sends the verify command. It then waits for the recovery interval, reads the byte back and compares it with the wanted value.

A byte that reads back wrong gets another pulse, up to a fixed limit. A byte that reads back right moves the sequencer to the next address. Once the last address passes, the sequencer puts the flash back in read mode, waits for the supply to ramp down and reports a pass. If a byte uses up its pulses, it stops at once, waits for the ramp-down and reports a fail together with the address that failed. All waits are counted in clock cycles, scaled from a clock-frequency parameter. The wanted data comes from an outside source, which is looked up by the address the block presents.

Top module: `fw_prog_seq`

## Requirements
- R1: While reset is held and right after it is released, `bus_wr`, `bus_rd`, `busy`, `done`, `pass` and `fail` are all 0.
- R2: After an accepted start, no bus strobe occurs for at least RAMP_US×CLK_MHZ cycles.
- R3: Each pulse is exactly these bus operations, in this order:
  - a write of 40h;
  - a write of `exp_data` to `bus_addr` = target address;
  - a write of C0h;
  - one read with `bus_addr` = target address.
  The flash returns `bus_rdata` in the cycle after the read strobe, and the value stays there.
- R4: At least PROG_US×CLK_MHZ cycles pass between the data write and the C0h write. At least VERIFY_US×CLK_MHZ cycles pass between the C0h write and the read.
- R5: A mismatching read-back repeats the pulse on the same address. Each address receives at most MAX_PULSES (default 25) pulses, and the count restarts for every new address.
- R6: Target addresses run from 0 upward by one to `end_addr`, which is sampled when start is accepted. A matching read-back moves to the next address.
- R7: After the last address matches, the block writes 00h once. After a ramp-down wait of at least RAMP_US×CLK_MHZ cycles it raises `done` with `pass`=1 and `fail`=0.
- R8: When the MAX_PULSES-th pulse on an address still mismatches, the block issues no further bus operation (no 00h). After the ramp-down wait it raises `done` with `fail`=1, `pass`=0 and `fail_addr` = that address.
- R9: `done` is high for exactly one cycle. `pass`, `fail` and `fail_addr` hold their values until the next accepted start, which clears them.
- R10: A start pulse while `busy` is 1 has no effect: the run in progress continues unchanged with its original range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run (sampled when idle) |
| end_addr | input | ADDR_W | Last address of the run |
| exp_addr | output | ADDR_W | Address whose wanted byte is requested |
| exp_data | input | DATA_W | Wanted byte for `exp_addr` |
| bus_addr | output | ADDR_W | Flash address |
| bus_wdata | output | DATA_W | Flash write data |
| bus_rdata | input | DATA_W | Flash read data, valid one cycle after `bus_rd` |
| bus_wr | output | 1 | Write strobe, one cycle per write |
| bus_rd | output | 1 | Read strobe, one cycle per read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run programmed every byte |
| fail | output | 1 | Last run hit the pulse limit |
| fail_addr | output | ADDR_W | Address that hit the pulse limit |

## Verification
A wrong sequencer state shows up on the bus at the very next strobe: a missing, extra or misplaced command write, or a read at the wrong address, breaks the expected operation stream within one pulse. A wrong pulse counter shows as the wrong number of data writes to a stubborn byte, or a verdict that comes out one pulse early or late. A wrong address counter shows as a skipped or repeated address. Timer faults show as strobes that come closer together than the program, recovery or ramp intervals allow. They are caught at the first pulse that follows the fault.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  localparam logic [7:0] CMD_PGM_SETUP = 8'h40;
  localparam logic [7:0] CMD_PGM_CHECK = 8'hC0;
  localparam logic [7:0] CMD_READ_MODE = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RAMPUP,
    S_SETUP,
    S_DATA,
    S_PROG,
    S_VCMD,
    S_RECOV,
    S_READ,
    S_CMP,
    S_RDCMD,
    S_RAMPDN
  } seq_state_t;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/seq_ctr.sv
module seq_ctr #(
  parameter int AW   = 8,
  parameter int MAXP = 25,
  parameter int PW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          adv_addr,
  input  logic          adv_pulse,
  output logic [AW-1:0] addr,
  output logic [PW-1:0] pulse,
  output logic          last_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      pulse <= PW'(1);
    end else if (clear) begin
      addr  <= '0;
      pulse <= PW'(1);
    end else if (adv_addr) begin
      addr  <= addr + 1'b1;
      pulse <= PW'(1);
    end else if (adv_pulse) begin
      pulse <= pulse + 1'b1;
    end
  end

  assign last_pulse = (pulse == PW'(MAXP));

  // R5
  pulse_range_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse >= PW'(1)) && (pulse <= PW'(MAXP)));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_addr && !clear) |=> (addr == $past(addr) + 1'b1) && (pulse == PW'(1)));

endmodule

// File: rtl/fw_prog_seq.sv
module fw_prog_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int CLK_MHZ    = 100,
  parameter int PROG_US    = 10,
  parameter int VERIFY_US  = 6,
  parameter int RAMP_US    = 2,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] exp_addr,
  input  logic [DATA_W-1:0] exp_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int PROG_CYC = (CLK_MHZ * PROG_US   > 0) ? CLK_MHZ * PROG_US   : 1;
  localparam int REC_CYC  = (CLK_MHZ * VERIFY_US > 0) ? CLK_MHZ * VERIFY_US : 1;
  localparam int RAMP_CYC = (CLK_MHZ * RAMP_US   > 0) ? CLK_MHZ * RAMP_US   : 1;
  localparam int MAX_CYC  = (PROG_CYC > REC_CYC) ?
                            ((PROG_CYC > RAMP_CYC) ? PROG_CYC : RAMP_CYC) :
                            ((REC_CYC  > RAMP_CYC) ? REC_CYC  : RAMP_CYC);
  localparam int TW       = $clog2(MAX_CYC + 1);
  localparam int PULSE_W  = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] PROG_LD = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] REC_LD  = TW'(REC_CYC - 1);
  localparam logic [TW-1:0] RAMP_LD = TW'(RAMP_CYC - 1);

  seq_state_t state, state_d;

  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              ctr_clear, ctr_adv_addr, ctr_adv_pulse;
  logic [ADDR_W-1:0] cur_addr;
  logic [PULSE_W-1:0] cur_pulse;
  logic              last_pulse;
  logic [ADDR_W-1:0] end_q, fa_q;
  logic [DATA_W-1:0] exp_q;
  logic              ok_q, hit, at_end;

  seq_timer #(.TW(TW)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  seq_ctr #(.AW(ADDR_W), .MAXP(MAX_PULSES), .PW(PULSE_W)) i_ctr (
    .clk        (clk),
    .rst        (rst),
    .clear      (ctr_clear),
    .adv_addr   (ctr_adv_addr),
    .adv_pulse  (ctr_adv_pulse),
    .addr       (cur_addr),
    .pulse      (cur_pulse),
    .last_pulse (last_pulse)
  );

  assign hit      = (bus_rdata == exp_q);
  assign at_end   = (cur_addr == end_q);
  assign exp_addr = cur_addr;

  always_comb begin
    state_d       = state;
    tmr_load      = 1'b0;
    tmr_val       = '0;
    ctr_clear     = 1'b0;
    ctr_adv_addr  = 1'b0;
    ctr_adv_pulse = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        state_d   = S_RAMPUP;
        tmr_load  = 1'b1;
        tmr_val   = RAMP_LD;
        ctr_clear = 1'b1;
      end
      S_RAMPUP: if (tmr_zero) state_d = S_SETUP;
      S_SETUP:  state_d = S_DATA;
      S_DATA: begin
        state_d  = S_PROG;
        tmr_load = 1'b1;
        tmr_val  = PROG_LD;
      end
      S_PROG: if (tmr_zero) state_d = S_VCMD;
      S_VCMD: begin
        state_d  = S_RECOV;
        tmr_load = 1'b1;
        tmr_val  = REC_LD;
      end
      S_RECOV: if (tmr_zero) state_d = S_READ;
      S_READ:  state_d = S_CMP;
      S_CMP: begin
        if (hit) begin
          if (at_end) begin
            state_d = S_RDCMD;
          end else begin
            ctr_adv_addr = 1'b1;
            state_d      = S_SETUP;
          end
        end else if (last_pulse) begin
          state_d  = S_RAMPDN;
          tmr_load = 1'b1;
          tmr_val  = RAMP_LD;
        end else begin
          ctr_adv_pulse = 1'b1;
          state_d       = S_SETUP;
        end
      end
      S_RDCMD: begin
        state_d  = S_RAMPDN;
        tmr_load = 1'b1;
        tmr_val  = RAMP_LD;
      end
      S_RAMPDN: if (tmr_zero) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      end_q <= '0;
      exp_q <= '0;
      ok_q  <= 1'b0;
      fa_q  <= '0;
    end else begin
      state <= state_d;
      if (state == S_IDLE && start) begin
        end_q <= end_addr;
        ok_q  <= 1'b0;
        fa_q  <= '0;
      end
      if (state_d == S_DATA) exp_q <= exp_data;
      if (state == S_CMP) begin
        if (hit && at_end) begin
          ok_q <= 1'b1;
        end else if (!hit && last_pulse) begin
          ok_q <= 1'b0;
          fa_q <= cur_addr;
        end
      end
    end
  end

  // registered bus side, decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      busy      <= 1'b0;
    end else begin
      bus_wr   <= (state_d == S_SETUP) || (state_d == S_DATA) ||
                  (state_d == S_VCMD)  || (state_d == S_RDCMD);
      bus_rd   <= (state_d == S_READ);
      busy     <= (state_d != S_IDLE);
      bus_addr <= ((state_d == S_DATA) || (state_d == S_READ)) ? cur_addr : '0;
      case (state_d)
        S_SETUP: bus_wdata <= DATA_W'(CMD_PGM_SETUP);
        S_DATA:  bus_wdata <= exp_data;
        S_VCMD:  bus_wdata <= DATA_W'(CMD_PGM_CHECK);
        S_RDCMD: bus_wdata <= DATA_W'(CMD_READ_MODE);
        default: bus_wdata <= '0;
      endcase
    end
  end

  // verdict side
  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE && start) begin
        pass      <= 1'b0;
        fail      <= 1'b0;
        fail_addr <= '0;
      end else if (state == S_RAMPDN && tmr_zero) begin
        done      <= 1'b1;
        pass      <= ok_q;
        fail      <= !ok_q;
        fail_addr <= fa_q;
      end
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  // R4
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_PROG && !tmr_zero) |=> (state == S_PROG));

  // R8
  fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> !bus_wr && !bus_rd);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(end_q));

endmodule

// File: tb/test_fw_prog_seq.sv
module test_fw_prog_seq;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MHZ = 2;
  localparam int MAXP = 25;
  localparam int PROG_CYC = MHZ * 10;
  localparam int REC_CYC  = MHZ * 6;
  localparam int RAMP_CYC = MHZ * 1;

  typedef struct packed {
    logic          rd;
    logic          chk_addr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } op_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] end_addr = '0;
  logic [AW-1:0] exp_addr, bus_addr, fail_addr;
  logic [DW-1:0] exp_data, bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_wr, bus_rd, busy, done, pass, fail;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t_start = 0, t_data = 0, t_vcmd = 0, t_last = 0;
  bit first_pending = 1'b0;
  op_t q[$];

  logic [DW-1:0] fmem [256];
  int need [256];
  int hits [256];
  bit armed = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 29 + 3);
  endfunction

  assign exp_data = pat(int'(exp_addr));

  fw_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .PROG_US(10),
                .VERIFY_US(6), .RAMP_US(1), .MAX_PULSES(MAXP)) i_fw_prog_seq (
    .clk(clk), .rst(rst), .start(start), .end_addr(end_addr),
    .exp_addr(exp_addr), .exp_data(exp_data), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_addr(fail_addr));

  // flash model: a byte takes only after need[] program writes
  always @(posedge clk) begin
    if (bus_wr) begin
      if (armed) begin
        hits[bus_addr] = hits[bus_addr] + 1;
        if (hits[bus_addr] >= need[bus_addr])
          fmem[bus_addr] <= fmem[bus_addr] & bus_wdata;
        armed <= 1'b0;
      end else begin
        armed <= (bus_wdata == 8'h40);
      end
    end
    if (bus_rd) bus_rdata <= fmem[bus_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the expected bus stream
  always @(negedge clk) begin
    if (!rst && (bus_wr || bus_rd)) begin
      if (first_pending) begin
        chk(cyc - t_start >= RAMP_CYC, "R2", "ramp-up gap", cyc - t_start, RAMP_CYC);
        first_pending = 1'b0;
      end
      if (q.size() == 0) begin
        chk(1'b0, "R3", "unexpected bus op addr", int'(bus_addr), 0);
      end else begin
        op_t e;
        e = q.pop_front();
        chk(bus_rd == e.rd, "R3", "op kind", int'(bus_rd), int'(e.rd));
        if (e.chk_addr)
          chk(bus_addr == e.addr, "R6", "target addr", int'(bus_addr), int'(e.addr));
        if (!e.rd && bus_wr) begin
          chk(bus_wdata == e.data, "R3", "write data", int'(bus_wdata), int'(e.data));
          if (e.chk_addr) t_data = cyc;
          if (e.data == 8'hC0 && !e.chk_addr) begin
            chk(cyc - t_data >= PROG_CYC, "R4", "program wait", cyc - t_data, PROG_CYC);
            t_vcmd = cyc;
          end
        end
        if (e.rd && bus_rd)
          chk(cyc - t_vcmd >= REC_CYC, "R4", "recovery wait", cyc - t_vcmd, REC_CYC);
      end
      t_last = cyc;
    end
  end

  task automatic reset_model();
    for (int i = 0; i < 256; i++) begin
      fmem[i] = 8'hFF;
      need[i] = 1;
      hits[i] = 0;
    end
  endtask

  task automatic plan(input int last, output bit ok, output int fa);
    ok = 1'b1;
    fa = 0;
    for (int a = 0; a <= last; a++) begin
      int k;
      k = (need[a] > MAXP) ? MAXP : need[a];
      for (int p = 0; p < k; p++) begin
        q.push_back('{1'b0, 1'b0, '0, 8'h40});
        q.push_back('{1'b0, 1'b1, AW'(a), pat(a)});
        q.push_back('{1'b0, 1'b0, '0, 8'hC0});
        q.push_back('{1'b1, 1'b1, AW'(a), '0});
      end
      if (need[a] > MAXP) begin
        ok = 1'b0;
        fa = a;
        break;
      end
    end
    if (ok) q.push_back('{1'b0, 1'b0, '0, 8'h00});
  endtask

  task automatic run(input int last, input int stray, input string tag);
    bit ok;
    int fa;
    int n;
    plan(last, ok, fa);
    @(negedge clk);
    end_addr = AW'(last);
    start = 1'b1;
    t_start = cyc;
    first_pending = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!pass && !fail, "R9", "verdict cleared by start", int'({pass, fail}), 0);
    if (stray > 0) begin
      repeat (stray) @(negedge clk);
      end_addr = AW'(last + 3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      end_addr = AW'(last);
    end
    n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      chk(1'b0, "R7", "watchdog: no done", 0, 1);
    end else begin
      chk(cyc - t_last >= RAMP_CYC, ok ? "R7" : "R8", "ramp-down gap", cyc - t_last, RAMP_CYC);
      chk(q.size() == 0, "R6", "ops left over", q.size(), 0);
      chk(pass == ok, ok ? "R7" : "R8", "pass flag", int'(pass), int'(ok));
      chk(fail == !ok, ok ? "R7" : "R8", "fail flag", int'(fail), int'(!ok));
      if (!ok) chk(fail_addr == AW'(fa), "R8", "fail_addr", int'(fail_addr), fa);
      if (stray > 0) chk(ok && q.size() == 0, "R10", tag, int'(pass), 1);
      @(negedge clk);
      chk(!done, "R9", "done width", int'(done), 0);
      repeat (6) @(negedge clk);
      chk(pass == ok && fail == !ok && !busy, "R9", "verdict hold",
          int'({pass, fail}), int'({ok, !ok}));
    end
    q.delete();
  endtask

  initial begin
    reset_model();
    repeat (3) @(negedge clk);
    chk(!bus_wr && !bus_rd && !busy && !done && !pass && !fail, "R1", "in reset",
        int'({bus_wr, bus_rd, busy, done, pass, fail}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_wr && !bus_rd && !busy && !done && !pass && !fail, "R1", "after reset",
        int'({bus_wr, bus_rd, busy, done, pass, fail}), 0);

    // several bytes, mixed retry counts, stray start mid-run (R5, R10)
    reset_model();
    need[0] = 1; need[1] = 3; need[2] = 1; need[3] = 2;
    run(3, 60, "stray start ignored");

    // single-byte range
    reset_model();
    run(0, 0, "");

    // exactly MAX_PULSES needed: still passes (R5)
    reset_model();
    need[0] = MAXP; need[1] = 1;
    run(1, 0, "");
    chk(hits[0] == MAXP, "R5", "pulses at limit", hits[0], MAXP);

    // byte never takes: fail at address 1, address 2 untouched (R8)
    reset_model();
    need[0] = 2; need[1] = 30; need[2] = 1;
    run(2, 0, "");
    chk(hits[1] == MAXP, "R5", "pulses before fail", hits[1], MAXP);
    chk(hits[2] == 0, "R8", "no write past failure", hits[2], 0);

    // clean pass after a fail
    reset_model();
    need[1] = 4;
    run(2, 0, "");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule